// File: doc/BRIEF.md
# Multichannel Input Range Error Monitor

This block watches the digitized samples of a four-channel converter and compares each one with a lower and an upper limit that are set per channel. A sample that falls outside its window raises one shared error output and sets a latched flag for the channel. It also clears the channel's conversion-complete flag and freezes the channel's output at the last good value. An alarm output blinks while the error is pending. The host drops the error with a clear request, and the request is only accepted once no channel is still out of range.

Recovery of the data path does not depend on the alarm. As soon as a channel delivers an in-range sample, its output updates again and its conversion-complete flag comes back. A one-cycle restart pulse tells the downstream averaging or lag filter to discard its history and start from that sample. This happens whether or not the host has cleared the error yet. Limit and enable settings are plain parallel inputs.

Each channel runs its own state machine with four states:
- `CH_OFF`: the channel is disabled.
- `CH_WAIT`: the channel is enabled but has not yet produced an output.
- `CH_RUN`: the output is valid.
- `CH_HOLD`: the output is frozen by a violation.

Transitions:
- Any state goes to `CH_OFF` when the channel enable is low.
- `CH_OFF` goes to `CH_WAIT` when it is enabled and has no sample.
- `CH_OFF`, `CH_WAIT` and `CH_RUN` go to `CH_RUN` on an in-range update.
- Any enabled state goes to `CH_HOLD` on a violation.
- `CH_HOLD` goes to `CH_RUN` on resumption, which is the first in-range sample.

The shared controller has two states, `AL_IDLE` and `AL_ACTIVE`. It moves from `AL_IDLE` to `AL_ACTIVE` when any channel violates its window. It moves back from `AL_ACTIVE` to `AL_IDLE` when a clear is accepted.

Top module: `range_alarm_monitor`

## Requirements
- R1: Samples and limits are two's-complement signed values. A sample is in range when lower <= sample <= upper, so both limit values themselves are in range.
- R2: A violation counts only when the global detect enable is high and the channel's enable bit is high. With detect disabled, an out-of-window sample updates the output like any other sample.
- R3: The error output goes high at the clock edge that samples a valid violating sample on any channel.
- R4: The violating channel's conversion-complete flag goes low at that same edge and stays low while the channel is in hold.
- R5: While a channel is in hold, its output keeps the last in-range value, and the violating sample is never loaded.
- R6: The alarm output is high for BLINK_DIV cycles starting at the edge where the error goes high. It then alternates low and high every BLINK_DIV cycles, and it is low whenever the error output is low.
- R7: A clear request is accepted only when all three of these hold:
  - the error output is high;
  - no channel is in hold;
  - no violation is sampled in the same cycle.
  When it is accepted, the error output, the alarm and all channel flags go low at the next edge.
- R8: A channel in hold that receives an in-range sample loads it into its output at that edge, even while the error output is still high.
- R9: The conversion-complete flag sets at the edge of the first output update after enable or after recovery.
- R10: The channel's filter-restart output pulses high for exactly one cycle, together with the first update that leaves hold.
- R11: A channel's error flag sets at its violation edge and stays set until a clear is accepted.
- R12: A channel whose enable bit is low ignores its samples, holds its output, and shows the conversion-complete flag low.
- R13: After reset, all outputs are low and every channel output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_en | input | 1 | Global enable for range detection |
| ch_en | input | NUM_CH | Per-channel conversion enable |
| smp_vld | input | NUM_CH | Per-channel new-sample strobe |
| smp_data | input | NUM_CH*DATA_W | Packed signed samples, channel 0 in the low bits |
| lo_lim | input | NUM_CH*DATA_W | Packed signed lower limits |
| hi_lim | input | NUM_CH*DATA_W | Packed signed upper limits |
| clr_req | input | 1 | Host request to clear the error |
| err_out | output | 1 | Shared latched range error |
| alarm | output | 1 | Blinking alarm indicator |
| ch_err_flag | output | NUM_CH | Latched per-channel error flags |
| done_flag | output | NUM_CH | Per-channel conversion-complete flags |
| dout | output | NUM_CH*DATA_W | Packed per-channel output values |
| filt_restart | output | NUM_CH | One-cycle filter history restart pulses |

## Verification
Two functions can fall in the same cycle: a host clear and a fresh violation. A related collision is a clear arriving in the cycle where a held channel receives its recovering sample. The bench drives these deliberately by pulsing the clear request in the same cycle as a violating sample on another channel. It also pulses the clear together with the in-range sample that releases a hold. Both cases must leave the error set, because a violation wins and a channel counted as holding blocks the clear. A behavioural reference model is compared on every clock with randomized limits, enables, samples and clears, so further collisions of this kind are also judged cycle by cycle.

// File: rtl/rng_mon_pkg.sv
package rng_mon_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2,
        CH_HOLD = 2'd3
    } ch_state_e;

    typedef enum logic {
        AL_IDLE   = 1'b0,
        AL_ACTIVE = 1'b1
    } al_state_e;

endpackage

// File: rtl/rng_mon_channel.sv
module rng_mon_channel
    import rng_mon_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     det_en,
    input  logic                     ch_en,
    input  logic                     smp_vld,
    input  logic signed [DATA_W-1:0] smp_data,
    input  logic signed [DATA_W-1:0] lo_lim,
    input  logic signed [DATA_W-1:0] hi_lim,
    input  logic                     clr_ok,
    output logic                     oor_evt,
    output logic                     in_hold,
    output logic                     err_flag,
    output logic                     done,
    output logic [DATA_W-1:0]        dout,
    output logic                     restart
);

    ch_state_e         st_q, st_d;
    logic              below, above;
    logic              load, resume;
    logic [DATA_W-1:0] dout_q;
    logic              restart_q;
    logic              flag_q;

    // Window comparison; both limit values count as in range.
    always_comb begin
        below   = smp_data < lo_lim;
        above   = smp_data > hi_lim;
        oor_evt = det_en && ch_en && smp_vld && (below || above);
    end

    // Next-state decision.
    always_comb begin
        st_d   = st_q;
        load   = 1'b0;
        resume = 1'b0;
        if (!ch_en) begin
            st_d = CH_OFF;
        end else begin
            unique case (st_q)
                CH_OFF, CH_WAIT, CH_RUN: begin
                    if (oor_evt) begin
                        st_d = CH_HOLD;
                    end else if (smp_vld) begin
                        st_d = CH_RUN;
                        load = 1'b1;
                    end else if (st_q == CH_OFF) begin
                        st_d = CH_WAIT;
                    end
                end
                CH_HOLD: begin
                    if (!oor_evt && smp_vld) begin
                        st_d   = CH_RUN;
                        load   = 1'b1;
                        resume = 1'b1;
                    end
                end
                default: st_d = CH_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q    <= '0;
            restart_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (load) dout_q <= smp_data;
            restart_q <= resume;
            if (clr_ok) flag_q <= 1'b0;
            else if (oor_evt) flag_q <= 1'b1;
        end
    end

    assign in_hold  = (st_q == CH_HOLD);
    assign done     = (st_q == CH_RUN);
    assign dout     = dout_q;
    assign restart  = restart_q;
    assign err_flag = flag_q;

    // R5: a held output changes only when leaving hold for a fresh update.
    a_r5_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_HOLD) |=> (st_q == CH_RUN || $stable(dout_q)));

    // R4: a violation clears the conversion-complete flag at the next edge.
    a_r4_done_drops: assert property (@(posedge clk) disable iff (!rst_n)
        oor_evt |=> !done);

    // R10: the restart pulse always accompanies a valid output.
    a_r10_restart_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        restart_q |-> done);

    // R12: a disabled channel never reports completion.
    a_r12_off_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> !done);

endmodule

// File: rtl/rng_mon_alarm.sv
module rng_mon_alarm
    import rng_mon_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int BLINK_DIV = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] oor_vec,
    input  logic [NUM_CH-1:0] hold_vec,
    input  logic              clr_req,
    output logic              clr_ok,
    output logic              err_out,
    output logic              alarm
);

    localparam int CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BLINK_DIV - 1);

    al_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             alarm_q;

    // A new violation or any channel still in hold blocks the clear.
    assign clr_ok = clr_req && (st_q == AL_ACTIVE) && !(|hold_vec) && !(|oor_vec);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            AL_IDLE:   if (|oor_vec) st_d = AL_ACTIVE;
            AL_ACTIVE: if (clr_ok)   st_d = AL_IDLE;
            default:   st_d = AL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= AL_IDLE;
        else        st_q <= st_d;
    end

    // Blink generator: BLINK_DIV cycles high, then BLINK_DIV low, repeating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            alarm_q <= 1'b0;
        end else if (st_d == AL_IDLE) begin
            cnt_q   <= '0;
            alarm_q <= 1'b0;
        end else if (st_q == AL_IDLE) begin
            cnt_q   <= '0;
            alarm_q <= 1'b1;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            alarm_q <= !alarm_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign err_out = (st_q == AL_ACTIVE);
    assign alarm   = alarm_q;

    // R3: any violation leaves the error set at the next edge.
    a_r3_err_on_violation: assert property (@(posedge clk) disable iff (!rst_n)
        (|oor_vec) |=> err_out);

    // R7: the error only falls after a clear request.
    a_r7_fall_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_out) |-> $past(clr_req));

    // R7: a channel still in hold keeps the error set.
    a_r7_hold_blocks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_out && (|hold_vec)) |=> err_out);

    // R6: the alarm is quiet when no error is pending.
    a_r6_alarm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !err_out |-> !alarm_q);

    // R6: the alarm starts high when the error rises.
    a_r6_alarm_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_out) |-> alarm_q);

endmodule

// File: rtl/range_alarm_monitor.sv
module range_alarm_monitor
    import rng_mon_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 16,
    parameter int BLINK_DIV = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     det_en,
    input  logic [NUM_CH-1:0]        ch_en,
    input  logic [NUM_CH-1:0]        smp_vld,
    input  logic [NUM_CH*DATA_W-1:0] smp_data,
    input  logic [NUM_CH*DATA_W-1:0] lo_lim,
    input  logic [NUM_CH*DATA_W-1:0] hi_lim,
    input  logic                     clr_req,
    output logic                     err_out,
    output logic                     alarm,
    output logic [NUM_CH-1:0]        ch_err_flag,
    output logic [NUM_CH-1:0]        done_flag,
    output logic [NUM_CH*DATA_W-1:0] dout,
    output logic [NUM_CH-1:0]        filt_restart
);

    logic [NUM_CH-1:0] oor_vec;
    logic [NUM_CH-1:0] hold_vec;
    logic              clr_ok;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rng_mon_channel #(
            .DATA_W (DATA_W)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .det_en   (det_en),
            .ch_en    (ch_en[c]),
            .smp_vld  (smp_vld[c]),
            .smp_data (smp_data[c*DATA_W +: DATA_W]),
            .lo_lim   (lo_lim[c*DATA_W +: DATA_W]),
            .hi_lim   (hi_lim[c*DATA_W +: DATA_W]),
            .clr_ok   (clr_ok),
            .oor_evt  (oor_vec[c]),
            .in_hold  (hold_vec[c]),
            .err_flag (ch_err_flag[c]),
            .done     (done_flag[c]),
            .dout     (dout[c*DATA_W +: DATA_W]),
            .restart  (filt_restart[c])
        );
    end

    rng_mon_alarm #(
        .NUM_CH    (NUM_CH),
        .BLINK_DIV (BLINK_DIV)
    ) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .oor_vec  (oor_vec),
        .hold_vec (hold_vec),
        .clr_req  (clr_req),
        .clr_ok   (clr_ok),
        .err_out  (err_out),
        .alarm    (alarm)
    );

    // R11: a latched channel flag always implies the shared error.
    a_r11_flag_implies_err: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_err_flag) |-> err_out);

    // R11: flags persist while the error is pending.
    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_out && !clr_req) |=> (ch_err_flag & $past(ch_err_flag)) == $past(ch_err_flag));

endmodule

// File: tb/range_alarm_monitor_bench.sv
`timescale 1ns/1ps
module range_alarm_monitor_bench;

    localparam int NC = 4;
    localparam int DW = 16;
    localparam int BD = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              det_en = 1'b0;
    logic [NC-1:0]     ch_en = '0;
    logic [NC-1:0]     smp_vld = '0;
    logic [NC*DW-1:0]  smp_data = '0;
    logic [NC*DW-1:0]  lo_lim = '0;
    logic [NC*DW-1:0]  hi_lim = '0;
    logic              clr_req = 1'b0;
    logic              err_out, alarm;
    logic [NC-1:0]     ch_err_flag, done_flag, filt_restart;
    logic [NC*DW-1:0]  dout;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    range_alarm_monitor #(.NUM_CH(NC), .DATA_W(DW), .BLINK_DIV(BD)) u_range_alarm_monitor (
        .clk(clk), .rst_n(rst_n), .det_en(det_en), .ch_en(ch_en), .smp_vld(smp_vld),
        .smp_data(smp_data), .lo_lim(lo_lim), .hi_lim(hi_lim), .clr_req(clr_req),
        .err_out(err_out), .alarm(alarm), .ch_err_flag(ch_err_flag), .done_flag(done_flag),
        .dout(dout), .filt_restart(filt_restart));

    // Behavioural reference: 0 off, 1 waiting, 2 running, 3 holding.
    int m_st[NC];
    int m_dout[NC];
    bit m_rs[NC];
    bit m_flag[NC];
    bit m_err, m_alarm;
    int m_cnt;

    function automatic int sval(input logic [NC*DW-1:0] v, input int c);
        logic signed [DW-1:0] t;
        t = v[c*DW +: DW];
        return int'(t);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_st[c]) begin m_st[c] = 0; m_dout[c] = 0; m_rs[c] = 0; m_flag[c] = 0; end
            m_err = 0; m_alarm = 0; m_cnt = 0;
        end else begin
            bit oor[NC];
            bit any_oor, any_hold, acc;
            any_oor = 0; any_hold = 0;
            for (int c = 0; c < NC; c++) begin
                int d;
                d = sval(smp_data, c);
                oor[c] = det_en && ch_en[c] && smp_vld[c] &&
                         (d < sval(lo_lim, c) || d > sval(hi_lim, c));
                if (oor[c]) any_oor = 1;
                if (m_st[c] == 3) any_hold = 1;
            end
            acc = clr_req && m_err && !any_hold && !any_oor;
            for (int c = 0; c < NC; c++) begin
                m_rs[c] = 0;
                if (!ch_en[c]) m_st[c] = 0;
                else if (oor[c]) m_st[c] = 3;
                else if (smp_vld[c]) begin
                    if (m_st[c] == 3) m_rs[c] = 1;
                    m_st[c] = 2;
                    m_dout[c] = sval(smp_data, c);
                end else if (m_st[c] == 0) m_st[c] = 1;
                if (acc) m_flag[c] = 0;
                else if (oor[c]) m_flag[c] = 1;
            end
            if (!m_err) begin
                if (any_oor) begin m_err = 1; m_alarm = 1; m_cnt = 0; end
            end else if (acc) begin
                m_err = 0; m_alarm = 0; m_cnt = 0;
            end else if (m_cnt == BD - 1) begin
                m_cnt = 0; m_alarm = !m_alarm;
            end else m_cnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 err_out", err_out, m_err);
            chk("R6 alarm", alarm, m_alarm);
            for (int c = 0; c < NC; c++) begin
                chk("R11 flag", ch_err_flag[c], m_flag[c]);
                chk("R4 done", done_flag[c], m_st[c] == 2);
                chk("R5 dout", sval(dout, c), m_dout[c]);
                chk("R10 restart", filt_restart[c], m_rs[c]);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        smp_vld = '0;
        clr_req = 1'b0;
    endtask

    task automatic put(input int c, input int v);
        smp_data[c*DW +: DW] = DW'(v);
        smp_vld[c] = 1'b1;
    endtask

    task automatic lim(input int c, input int lo, input int hi);
        lo_lim[c*DW +: DW] = DW'(lo);
        hi_lim[c*DW +: DW] = DW'(hi);
    endtask

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        #0;
        // R13: reset state
        chk("R13 err", err_out, 0);
        chk("R13 alarm", alarm, 0);
        chk("R13 done", done_flag, 0);
        chk("R13 dout", int'(dout == '0), 1);
        for (int c = 0; c < NC; c++) lim(c, -10, 20);
        det_en = 1; ch_en = '1;
        put(0, 20); tick();
        chk("R1 upper edge in range", err_out, 0);
        chk("R9 done after update", done_flag[0], 1);
        put(0, -10); tick();
        chk("R1 lower edge in range", sval(dout, 0), -10);
        det_en = 0; put(1, 50); tick();
        chk("R2 detect off", err_out, 0);
        chk("R2 detect off update", sval(dout, 1), 50);
        det_en = 1; put(0, 21); tick();
        chk("R3 err rises", err_out, 1);
        chk("R4 done drops", done_flag[0], 0);
        chk("R5 frozen value", sval(dout, 0), -10);
        chk("R6 alarm starts high", alarm, 1);
        tick(); tick();
        chk("R6 alarm still high", alarm, 1);
        tick();
        chk("R6 alarm toggles low", alarm, 0);
        clr_req = 1; tick();
        chk("R7 clear refused in hold", err_out, 1);
        clr_req = 1; put(0, 5); tick();
        chk("R7 clear refused on release cycle", err_out, 1);
        chk("R8 resume while err", sval(dout, 0), 5);
        chk("R9 done back", done_flag[0], 1);
        chk("R10 restart pulse", filt_restart[0], 1);
        chk("R11 flag kept", ch_err_flag[0], 1);
        tick();
        chk("R10 restart one cycle", filt_restart[0], 0);
        clr_req = 1; tick();
        chk("R7 cleared", err_out, 0);
        chk("R7 alarm off", alarm, 0);
        chk("R11 flag cleared", ch_err_flag[0], 0);
        ch_en[2] = 0; put(2, 100); tick();
        chk("R12 disabled ignored", err_out, 0);
        chk("R12 disabled not done", done_flag[2], 0);
        ch_en[2] = 1; put(2, 3); tick();
        chk("R12 enabled update", sval(dout, 2), 3);
        put(3, 90); tick();
        put(3, 0); tick();
        clr_req = 1; put(1, -40); tick();
        chk("R7 violation beats clear", err_out, 1);
        chk("R11 new flag", ch_err_flag[1], 1);
        put(1, 0); tick();
        clr_req = 1; tick();
        chk("R7 final clear", err_out, 0);
        // Randomized phase, judged by the every-cycle comparison.
        for (int i = 0; i < 4000; i++) begin
            if (i % 200 == 0)
                for (int c = 0; c < NC; c++)
                    lim(c, -int'($urandom_range(120)), int'($urandom_range(120)));
            det_en = ($urandom_range(9) != 0);
            ch_en = ($urandom_range(7) == 0) ? 4'($urandom) : '1;
            for (int c = 0; c < NC; c++)
                if ($urandom_range(2) == 0) put(c, int'($urandom_range(300)) - 150);
            clr_req = ($urandom_range(5) == 0);
            tick();
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule